// File: doc/BRIEF.md
# Packed Halfword Vector Add Unit

This execute unit takes one 32-bit vector instruction word and two 128-bit operand values. It splits each operand into eight 16-bit lanes and adds the lanes pairwise in one of three forms: a wrapping add, an unsigned clamping add and a signed clamping add. The instruction word is decoded inside the unit. The unit recognises only these three halfword add forms. Every other instruction is reported as not handled, because the result-valid output stays low for it.

An instruction is presented with `issue` high for one cycle. Its result, its destination register index and a valid flag are registered and appear after the next rising clock edge. The register file and hazard handling lie outside the unit. Operands therefore arrive as values, and a destination that names one of its own sources still sees the values read before the write.

The unit also keeps a sticky saturation status, built as a two-state machine. In `ST_CLEAR` the flag reads 0. The `go_set` transition moves it to `ST_SET` when a clamping add clamps any lane in an issued instruction. In `ST_SET` the flag reads 1. The `go_clear` transition returns it to `ST_CLEAR` when `sat_clr` is pulsed and no clamp happens in the same cycle. In all other cycles the `stay` transition keeps the current state.

Top module: `hvadd_unit`

## Requirements
- R1: Each 128-bit operand and the result are split into eight 16-bit lanes. Lane 0 is bits [127:112], and lane k is bits [127-16k : 112-16k].
- R2: The primary opcode is insn[31:26] and must equal 4. The extended opcode is insn[10:0]. The value 64 selects the wrapping add, where each result lane is (A+B) mod 65536. This form never changes the saturation flag.
- R3: Extended opcode 576 selects the unsigned clamping add. A lane whose true sum exceeds 0xFFFF gives 0xFFFF.
- R4: Extended opcode 832 selects the signed clamping add. An overflow exists when both lane operands have the same sign bit and the sign bit of the wrapped sum differs from it. On an overflow the lane gives 0x7FFF for positive operands and 0x8000 for negative operands.
- R5: The destination index is insn[25:21]. For a handled instruction it appears on `res_dst`.
- R6: If the primary opcode or the extended opcode is anything else, the instruction is not handled. In the following cycle `res_valid` is low, `res_data` and `res_dst` hold their previous values, and the saturation flag is unchanged.
- R7: A handled instruction issued at a rising edge drives `res_valid` high during the cycle after that edge only. The result belongs to that issue.
- R8: The saturation flag is set by any lane that clamps in an issued clamping add. It stays set until `sat_clr` is pulsed. If a clear and a new clamp happen in the same cycle, the flag stays set.
- R9: While reset is active, `res_valid`, `res_data`, `res_dst` and `sat_flag` are all 0.
- R10: The source register fields insn[20:16] and insn[15:11] have no effect on the result. This holds even when they equal the destination field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | Instruction present this cycle |
| insn | input | 32 | Instruction word |
| src_a | input | 128 | First operand value |
| src_b | input | 128 | Second operand value |
| sat_clr | input | 1 | Clear pulse for the saturation flag |
| res_valid | output | 1 | Registered result is from a handled instruction |
| res_data | output | 128 | Registered lane-wise sum |
| res_dst | output | 5 | Registered destination register index |
| sat_flag | output | 1 | Sticky saturation status |

## Verification
Two things can happen in the same cycle: a lane clamps, and a clear pulse arrives. The bench forces both together in several ways. It pulses `sat_clr` together with a clamping add, with a clamp-free clamping add, and with a wrapping add that overflows. It also pulses `sat_clr` on a regular cadence during the lane sweeps. A reference model in the bench keeps its own flag, computed as the old flag with the clear applied, ORed with any clamp. The bench compares `sat_flag` against this model after every step. It also compares the lane sums against arithmetic done in plain integers.

// File: rtl/hvadd_pkg.sv
package hvadd_pkg;
    typedef enum logic [1:0] {
        OP_NONE,
        OP_MOD,
        OP_USAT,
        OP_SSAT
    } add_op_e;

    typedef enum logic {
        ST_CLEAR,
        ST_SET
    } sticky_e;

    localparam int unsigned INSN_W  = 32;
    localparam int unsigned PRIM_W  = 6;
    localparam int unsigned REG_W   = 5;
    localparam int unsigned XO_W    = 11;

    localparam logic [PRIM_W-1:0] PRIM_VEC = 6'd4;
    localparam logic [XO_W-1:0]   XO_MOD   = 11'd64;
    localparam logic [XO_W-1:0]   XO_USAT  = 11'd576;
    localparam logic [XO_W-1:0]   XO_SSAT  = 11'd832;
endpackage

// File: rtl/hvadd_decode.sv
module hvadd_decode
    import hvadd_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output add_op_e           op,
    output logic [REG_W-1:0]  dst
);
    localparam int unsigned PRIM_LO = INSN_W - PRIM_W;
    localparam int unsigned DST_LO  = PRIM_LO - REG_W;

    logic [PRIM_W-1:0] prim;
    logic [XO_W-1:0]   xo;

    assign prim = insn[INSN_W-1:PRIM_LO];
    assign xo   = insn[XO_W-1:0];
    assign dst  = insn[PRIM_LO-1:DST_LO];

    always_comb begin
        op = OP_NONE;
        if (prim == PRIM_VEC) begin
            case (xo)
                XO_MOD:  op = OP_MOD;
                XO_USAT: op = OP_USAT;
                XO_SSAT: op = OP_SSAT;
                default: op = OP_NONE;
            endcase
        end
    end
endmodule

// File: rtl/hvadd_lane.sv
module hvadd_lane
    import hvadd_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  add_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum,
    output logic         clamped
);
    localparam logic [W-1:0] U_MAX = {W{1'b1}};
    localparam logic [W-1:0] S_MAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] S_MIN = {1'b1, {(W-1){1'b0}}};

    logic [W:0] wide;
    logic       s_ov;

    assign wide = {1'b0, a} + {1'b0, b};
    assign s_ov = (a[W-1] == b[W-1]) && (wide[W-1] != a[W-1]);

    always_comb begin
        sum     = wide[W-1:0];
        clamped = 1'b0;
        unique case (op)
            OP_USAT: begin
                if (wide[W]) begin
                    sum     = U_MAX;
                    clamped = 1'b1;
                end
            end
            OP_SSAT: begin
                if (s_ov) begin
                    sum     = a[W-1] ? S_MIN : S_MAX;
                    clamped = 1'b1;
                end
            end
            OP_MOD, OP_NONE: begin
                sum     = wide[W-1:0];
                clamped = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/hvadd_sticky.sv
module hvadd_sticky
    import hvadd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr,
    output logic flag
);
    sticky_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_CLEAR: if (set_evt) state_nx = ST_SET;
            ST_SET:   if (clr && !set_evt) state_nx = ST_CLEAR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_CLEAR;
        else        state <= state_nx;
    end

    always_comb begin
        unique case (state)
            ST_CLEAR: flag = 1'b0;
            ST_SET:   flag = 1'b1;
        endcase
    end

    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> flag);
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set_evt) |=> !flag);
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !set_evt) |=> $stable(flag));
endmodule

// File: rtl/hvadd_unit.sv
module hvadd_unit
    import hvadd_pkg::*;
#(
    parameter int unsigned LANES  = 8,
    parameter int unsigned LANE_W = 16,
    localparam int unsigned VEC_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic [INSN_W-1:0] insn,
    input  logic [VEC_W-1:0]  src_a,
    input  logic [VEC_W-1:0]  src_b,
    input  logic              sat_clr,
    output logic              res_valid,
    output logic [VEC_W-1:0]  res_data,
    output logic [REG_W-1:0]  res_dst,
    output logic              sat_flag
);
    add_op_e          dec_op;
    logic [REG_W-1:0] dec_dst;
    logic [VEC_W-1:0] lane_sum;
    logic [LANES-1:0] lane_clamp;
    logic             op_ok;
    logic             sat_evt;

    hvadd_decode u_decode (
        .insn (insn),
        .op   (dec_op),
        .dst  (dec_dst)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int unsigned HI = VEC_W - 1 - g * LANE_W;
        hvadd_lane #(.W(LANE_W)) u_lane (
            .op      (dec_op),
            .a       (src_a[HI -: LANE_W]),
            .b       (src_b[HI -: LANE_W]),
            .sum     (lane_sum[HI -: LANE_W]),
            .clamped (lane_clamp[g])
        );
    end

    assign op_ok   = issue && (dec_op != OP_NONE);
    assign sat_evt = op_ok && (|lane_clamp);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_data  <= '0;
            res_dst   <= '0;
        end else begin
            res_valid <= op_ok;
            if (op_ok) begin
                res_data <= lane_sum;
                res_dst  <= dec_dst;
            end
        end
    end

    hvadd_sticky u_sticky (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (sat_evt),
        .clr     (sat_clr),
        .flag    (sat_flag)
    );

    p_mod_keeps_sat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && dec_op == OP_MOD && !sat_clr) |=> $stable(sat_flag));
    p_unhandled_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && dec_op == OP_NONE) |=> (!res_valid && $stable(res_data) && $stable(res_dst)));
    p_usat_no_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && dec_op == OP_USAT)
            |=> res_data[VEC_W-1 -: LANE_W] >= $past(src_a[VEC_W-1 -: LANE_W]));
    p_one_cycle_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !issue |=> !res_valid);
endmodule

// File: tb/test_hvadd_unit.sv
`timescale 1ns/1ps
module test_hvadd_unit;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         issue;
    logic [31:0]  insn;
    logic [127:0] src_a, src_b;
    logic         sat_clr;
    logic         res_valid;
    logic [127:0] res_data;
    logic [4:0]   res_dst;
    logic         sat_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [127:0] m_data;
    logic [4:0]   m_dst;
    logic         m_sat;

    always #2.5 clk = ~clk;

    hvadd_unit i_hvadd_unit (
        .clk(clk), .rst_n(rst_n), .issue(issue), .insn(insn),
        .src_a(src_a), .src_b(src_b), .sat_clr(sat_clr),
        .res_valid(res_valid), .res_data(res_data), .res_dst(res_dst),
        .sat_flag(sat_flag)
    );

    function automatic logic [31:0] mk(input int prim, input int rd, input int ra,
                                       input int rb, input int xo);
        return {prim[5:0], rd[4:0], ra[4:0], rb[4:0], xo[10:0]};
    endfunction

    // kind: 0 wrap, 1 unsigned clamp, 2 signed clamp
    function automatic logic [15:0] ref_lane(input int kind, input logic [15:0] a,
                                             input logic [15:0] b, output bit cl);
        int u, s;
        cl = 0;
        u = int'(a) + int'(b);
        s = int'($signed(a)) + int'($signed(b));
        if (kind == 1) begin
            if (u > 65535) begin cl = 1; return 16'hFFFF; end
            return u[15:0];
        end
        if (kind == 2) begin
            if (s > 32767)  begin cl = 1; return 16'h7FFF; end
            if (s < -32768) begin cl = 1; return 16'h8000; end
            return s[15:0];
        end
        return u[15:0];
    endfunction

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Issue one instruction; check outputs after the capturing edge.
    task automatic run(input int prim, input int xo, input int rd, input int ra, input int rb,
                       input logic [127:0] a, input logic [127:0] b, input bit clr,
                       input string req);
        int kind;
        bit legal, any_cl, cl;
        logic [127:0] e;
        legal = (prim == 4) && (xo == 64 || xo == 576 || xo == 832);
        kind = (xo == 576) ? 1 : (xo == 832) ? 2 : 0;
        any_cl = 0;
        e = '0;
        for (int l = 0; l < 8; l++) begin
            e[127-16*l -: 16] = ref_lane(kind, a[127-16*l -: 16], b[127-16*l -: 16], cl);
            any_cl |= cl;
        end
        @(negedge clk);
        issue = 1'b1; insn = mk(prim, rd, ra, rb, xo);
        src_a = a; src_b = b; sat_clr = clr;
        @(negedge clk);
        issue = 1'b0; sat_clr = 1'b0; insn = '0;
        m_sat = (m_sat & ~clr) | (legal & any_cl);
        if (legal) begin m_data = e; m_dst = rd[4:0]; end
        chk(res_valid == legal, {req, " valid (R7 R6)"}, 128'(res_valid), 128'(legal));
        chk(res_data == m_data, {req, " data (R1)"}, res_data, m_data);
        chk(res_dst == m_dst, {req, " dst (R5)"}, 128'(res_dst), 128'(m_dst));
        chk(sat_flag == m_sat, {req, " sat (R8)"}, 128'(sat_flag), 128'(m_sat));
        @(negedge clk);
        chk(res_valid == 1'b0, {req, " valid drops (R7)"}, 128'(res_valid), 128'(0));
    endtask

    logic [15:0] cv [12];

    initial begin
        #1_000_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [127:0] a, b;
        logic [31:0] lfsr;
        cv = '{16'h0000, 16'h0001, 16'h7FFE, 16'h7FFF, 16'h8000, 16'h8001,
               16'hFFFE, 16'hFFFF, 16'h1234, 16'h4000, 16'hC000, 16'h00FF};
        rst_n = 1'b0; issue = 1'b0; insn = '0; src_a = '0; src_b = '0; sat_clr = 1'b0;
        m_data = '0; m_dst = '0; m_sat = 1'b0;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(!res_valid && res_data == '0 && res_dst == '0 && !sat_flag, "R9 reset",
            {res_valid, sat_flag, res_dst, res_data[120:0]}, 128'(0));
        rst_n = 1'b1;

        // R1 lane order: lane 0 only
        run(4, 64, 3, 0, 0, {16'h0102, 112'h0}, {16'h0010, 112'h0}, 0, "R1 lane0");
        chk(res_data[127:112] == 16'h0112, "R1 lane0 msb", res_data, 128'h0112);

        // R2 wrap add with overflow keeps flag at 0
        run(4, 64, 7, 1, 2, {8{16'hFFFF}}, {8{16'h0002}}, 0, "R2 wrap overflow");
        chk(!sat_flag, "R2 flag untouched", 128'(sat_flag), 128'(0));
        // R3 unsigned clamp sets flag
        run(4, 576, 9, 0, 0, {16'hFFF0, 112'h0}, {16'h0020, 112'h0}, 0, "R3 clamp");
        chk(res_data[127:112] == 16'hFFFF, "R3 clamp value", res_data, 128'hFFFF);
        // R2 wrap add while set keeps flag at 1
        run(4, 64, 2, 0, 0, '0, '0, 0, "R2 wrap while set");
        // R8 clear alone
        run(4, 576, 1, 0, 0, '0, '0, 1, "R8 clear no clamp");
        chk(!sat_flag, "R8 cleared", 128'(sat_flag), 128'(0));
        // R8 clear with clamp in same cycle: stays set
        run(4, 832, 4, 0, 0, {8{16'h7FFF}}, {8{16'h0001}}, 1, "R8 clear+clamp");
        chk(sat_flag, "R8 clamp wins", 128'(sat_flag), 128'(1));
        // R4 negative clamp
        run(4, 832, 5, 0, 0, {8{16'h8000}}, {8{16'hFFFF}}, 0, "R4 neg clamp");
        chk(res_data[15:0] == 16'h8000, "R4 neg value", res_data, 128'h8000);
        // R8 clear pulse without issue
        @(negedge clk); sat_clr = 1'b1; @(negedge clk); sat_clr = 1'b0; m_sat = 1'b0;
        chk(!sat_flag && !res_valid, "R8 idle clear", 128'(sat_flag), 128'(0));
        // R6 unhandled: bad primary, bad extended; clamp-worthy operands
        run(5, 576, 11, 0, 0, {8{16'hFFFF}}, {8{16'hFFFF}}, 0, "R6 bad primary");
        run(4, 577, 12, 0, 0, {8{16'hFFFF}}, {8{16'hFFFF}}, 0, "R6 bad extended");
        run(4, 0, 13, 0, 0, {8{16'h8000}}, {8{16'h8000}}, 0, "R6 zero extended");
        chk(!sat_flag, "R6 flag unchanged", 128'(sat_flag), 128'(0));
        // R10 aliasing: source fields equal destination, result unchanged
        run(4, 64, 6, 6, 6, {8{16'h1111}}, {8{16'h2222}}, 0, "R10 alias a");
        run(4, 64, 6, 31, 17, {8{16'h1111}}, {8{16'h2222}}, 0, "R10 alias b");
        chk(res_data == {8{16'h3333}}, "R10 same value", res_data, {8{16'h3333}});

        // Corner sweep, all three forms, lanes rotated
        for (int f = 0; f < 3; f++) begin
            for (int ia = 0; ia < 12; ia++) begin
                for (int ib = 0; ib < 12; ib++) begin
                    for (int l = 0; l < 8; l++) begin
                        a[127-16*l -: 16] = cv[(ia + l) % 12];
                        b[127-16*l -: 16] = cv[(ib + 3*l) % 12];
                    end
                    run(4, (f == 0) ? 64 : (f == 1) ? 576 : 832, (ia + ib) % 32, ia, ib,
                        a, b, ((ia + ib) % 5) == 0,
                        (f == 0) ? "R2 sweep" : (f == 1) ? "R3 sweep" : "R4 sweep");
                end
            end
        end

        // Pseudo-random sweep including unhandled forms
        lfsr = 32'h1ACE_B00C;
        for (int n = 0; n < 400; n++) begin
            for (int w = 0; w < 4; w++) begin
                lfsr = lfsr * 32'd1664525 + 32'd1013904223; a[32*w +: 32] = lfsr;
                lfsr = lfsr * 32'd1664525 + 32'd1013904223; b[32*w +: 32] = lfsr;
            end
            run((n % 9 == 0) ? 3 : 4,
                (n % 4 == 0) ? 64 : (n % 4 == 1) ? 576 : (n % 4 == 2) ? 832 : 320,
                n % 32, (n * 7) % 32, (n * 3) % 32, a, b, (n % 6) == 0, "R6 R4 random");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule